// File: doc/BRIEF.md
# Dual Operand Address Generator with Circular Wrap

This block produces byte addresses for two operand ports, called X and Y, that read a 64 KB byte-addressed data space of 16-bit words. Each port takes a pointer and an update command, and one clock later returns two values. The first is the effective address for the access. The second is the pointer after its post-update, ready to be written back to the pointer register by the surrounding datapath. Both ports work at the same time and neither depends on the other, so a dual-operand instruction can fetch two words in one cycle.

Each port can confine its pointer to a circular buffer defined by a start and an end word address. When the pointer steps off either end of the buffer, it wraps to the other end in hardware, so software needs no boundary tests. The X port has one further mode: a reverse-carry increment. This visits the entries of a radix-2 FFT buffer in bit-reversed order. X-side circular wrap works for any access, including single-operand accesses.

All addresses are word aligned. Address bit 0 is always cleared, and a pointer moves by 2 for each word.

Top module: `dual_agu`

## Requirements
- R1: While `rst` is high, and on the first cycle after it falls, every output is zero: `x_valid`, `y_valid`, `x_ea`, `x_next`, `y_ea` and `y_next`.
- R2: A request sampled on a clock edge raises that port's valid output for the following cycle only. In that cycle the effective address equals the request pointer with bit 0 cleared. In a cycle with no request, valid is low and both address outputs keep their previous values.
- R3: Command 2'b01 (post-increment) with no special mode gives an updated pointer equal to the aligned pointer plus 2, modulo 2^16. 0xFFFE steps to 0x0000.
- R4: Command 2'b10 (post-decrement) with no special mode gives the aligned pointer minus 2, modulo 2^16. 0x0000 steps to 0xFFFE.
- R5: Commands 2'b00 and 2'b11 leave the pointer unchanged. The updated pointer equals the aligned request pointer.
- R6: With circular enable set, an increment from a pointer whose word address equals the buffer end word address yields the buffer start address. Any other increment yields pointer plus 2.
- R7: With circular enable set, a decrement from a pointer whose word address equals the buffer start word address yields the buffer end address. Any other decrement yields pointer minus 2.
- R8: On the X port, an increment with bit-reverse enable set adds the modifier to the pointer over address bits 15 down to 1. The carry runs from bit 15 toward bit 1, and a carry out of bit 1 is dropped. Bit 0 of the result is zero.
- R9: On the X port, when bit-reverse and circular enable are both set on an increment, the bit-reversed result is used and the circular wrap is not applied.
- R10: On the X port, bit-reverse enable has no effect on decrement or hold commands. These behave as R4, R5 and R7 describe.
- R11: X and Y requests in the same cycle are both answered in the next cycle. Each port's result depends only on that port's own inputs.
- R12: Bit 0 of every effective address and every updated pointer is zero, even when the request pointer, buffer bounds or modifier have bit 0 set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| x_req | input | 1 | X port request strobe |
| x_cmd | input | 2 | X update command: 00 hold, 01 increment, 10 decrement, 11 hold |
| x_ptr | input | 16 | X pointer value |
| x_circ_en | input | 1 | X circular-buffer enable |
| x_buf_start | input | 16 | X circular buffer first word address |
| x_buf_end | input | 16 | X circular buffer last word address |
| x_brev_en | input | 1 | X bit-reversed increment enable |
| x_brev_mod | input | 16 | X bit-reverse modifier (byte units) |
| y_req | input | 1 | Y port request strobe |
| y_cmd | input | 2 | Y update command, same encoding as X |
| y_ptr | input | 16 | Y pointer value |
| y_circ_en | input | 1 | Y circular-buffer enable |
| y_buf_start | input | 16 | Y circular buffer first word address |
| y_buf_end | input | 16 | Y circular buffer last word address |
| x_valid | output | 1 | X result valid |
| x_ea | output | 16 | X effective address |
| x_next | output | 16 | X updated pointer |
| y_valid | output | 1 | Y result valid |
| y_ea | output | 16 | Y effective address |
| y_next | output | 16 | Y updated pointer |

## Verification
On the X port, a circular-buffer wrap and a bit-reversed increment can both be requested in the same cycle. The bench provokes this with a pointer sitting exactly on the buffer end while bit-reverse is enabled, chosen so that the wrap result and the reverse-carry result differ, and accepts only the reverse-carry value. In the same cycle the Y port performs its own circular wrap, so the test also confirms that the two ports, updating together, do not disturb each other.

// File: rtl/agu_pkg.sv
package agu_pkg;
  typedef enum logic [1:0] {
    CMD_HOLD = 2'b00,
    CMD_INC  = 2'b01,
    CMD_DEC  = 2'b10,
    CMD_KEEP = 2'b11
  } agu_cmd_e;
endpackage

// File: rtl/agu_step.sv
// Linear or circular one-word step on a word address (byte address >> 1).
module agu_step
  import agu_pkg::*;
#(
  parameter int WW = 15
) (
  input  logic [WW-1:0] ptr_w,
  input  logic [1:0]    cmd,
  input  logic          circ_en,
  input  logic [WW-1:0] start_w,
  input  logic [WW-1:0] end_w,
  output logic [WW-1:0] nxt_w
);
  logic [WW-1:0] inc_w;
  logic [WW-1:0] dec_w;
  logic          at_end;
  logic          at_start;

  assign inc_w    = ptr_w + WW'(1);
  assign dec_w    = ptr_w - WW'(1);
  assign at_end   = (ptr_w == end_w);
  assign at_start = (ptr_w == start_w);

  always_comb begin
    unique case (agu_cmd_e'(cmd))
      CMD_INC:  nxt_w = (circ_en && at_end)   ? start_w : inc_w;
      CMD_DEC:  nxt_w = (circ_en && at_start) ? end_w   : dec_w;
      default:  nxt_w = ptr_w;
    endcase
  end
endmodule

// File: rtl/agu_brev.sv
// Reverse-carry adder: the carry travels from the top bit toward bit 0.
module agu_brev #(
  parameter int WW = 15
) (
  input  logic [WW-1:0] a_w,
  input  logic [WW-1:0] m_w,
  output logic [WW-1:0] s_w
);
  logic [WW-1:0] a_r;
  logic [WW-1:0] m_r;
  logic [WW-1:0] s_r;

  for (genvar i = 0; i < WW; i++) begin : g_rev
    assign a_r[i] = a_w[WW-1-i];
    assign m_r[i] = m_w[WW-1-i];
    assign s_w[i] = s_r[WW-1-i];
  end

  assign s_r = a_r + m_r;
endmodule

// File: rtl/agu_port.sv
// One operand port: step selection plus registered outputs.
module agu_port
  import agu_pkg::*;
#(
  parameter int AW       = 16,
  parameter bit HAS_BREV = 1'b1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req,
  input  logic [1:0]    cmd,
  input  logic [AW-1:0] ptr,
  input  logic          circ_en,
  input  logic [AW-1:0] buf_start,
  input  logic [AW-1:0] buf_end,
  input  logic          brev_en,
  input  logic [AW-1:0] brev_mod,
  output logic          valid,
  output logic [AW-1:0] ea,
  output logic [AW-1:0] nxt
);
  localparam int WW = AW - 1;

  logic [WW-1:0] ptr_w;
  logic [WW-1:0] start_w;
  logic [WW-1:0] end_w;
  logic [WW-1:0] mod_w;
  logic [WW-1:0] step_w;
  logic [WW-1:0] rev_w;
  logic [WW-1:0] upd_w;
  logic          brev_sel;
  logic          unused_low;

  assign ptr_w      = ptr[AW-1:1];
  assign start_w    = buf_start[AW-1:1];
  assign end_w      = buf_end[AW-1:1];
  assign mod_w      = brev_mod[AW-1:1];
  assign unused_low = ^{ptr[0], buf_start[0], buf_end[0], brev_mod[0]};

  agu_step #(.WW(WW)) u_step (
    .ptr_w   (ptr_w),
    .cmd     (cmd),
    .circ_en (circ_en),
    .start_w (start_w),
    .end_w   (end_w),
    .nxt_w   (step_w)
  );

  if (HAS_BREV) begin : g_brev
    agu_brev #(.WW(WW)) u_brev (
      .a_w (ptr_w),
      .m_w (mod_w),
      .s_w (rev_w)
    );
    assign brev_sel = brev_en && (agu_cmd_e'(cmd) == CMD_INC);
  end else begin : g_nobrev
    logic unused_brev;
    assign unused_brev = brev_en ^ (^mod_w);
    assign rev_w       = '0;
    assign brev_sel    = 1'b0;
  end

  // Bit-reverse outranks circular wrap.
  assign upd_w = brev_sel ? rev_w : step_w;

  always_ff @(posedge clk) begin
    if (rst) begin
      valid <= 1'b0;
      ea    <= '0;
      nxt   <= '0;
    end else begin
      valid <= req;
      if (req) begin
        ea  <= {ptr_w, 1'b0};
        nxt <= {upd_w, 1'b0};
      end
    end
  end

  // ---------------- assertions ----------------
  assert_valid_follows_req_R2: assert property (@(posedge clk) disable iff (rst)
    req |=> valid);

  assert_idle_hold_R2: assert property (@(posedge clk) disable iff (rst)
    !req |=> (!valid && $stable(ea) && $stable(nxt)));

  assert_aligned_R12: assert property (@(posedge clk) disable iff (rst)
    valid |-> (ea[0] == 1'b0 && nxt[0] == 1'b0));

  assert_linear_inc_R3: assert property (@(posedge clk) disable iff (rst)
    (req && cmd == 2'b01 && !circ_en && !(HAS_BREV && brev_en))
    |=> nxt == $past({ptr[AW-1:1], 1'b0}) + AW'(2));

  assert_linear_dec_R4: assert property (@(posedge clk) disable iff (rst)
    (req && cmd == 2'b10 && !circ_en)
    |=> nxt == $past({ptr[AW-1:1], 1'b0}) - AW'(2));

  assert_circ_inc_wrap_R6: assert property (@(posedge clk) disable iff (rst)
    (req && cmd == 2'b01 && circ_en && !(HAS_BREV && brev_en) &&
     ptr[AW-1:1] == buf_end[AW-1:1])
    |=> nxt == $past({buf_start[AW-1:1], 1'b0}));

  assert_circ_dec_wrap_R7: assert property (@(posedge clk) disable iff (rst)
    (req && cmd == 2'b10 && circ_en && ptr[AW-1:1] == buf_start[AW-1:1])
    |=> nxt == $past({buf_end[AW-1:1], 1'b0}));

  assert_hold_R5: assert property (@(posedge clk) disable iff (rst)
    (req && (cmd == 2'b00 || cmd == 2'b11))
    |=> nxt == $past({ptr[AW-1:1], 1'b0}));
endmodule

// File: rtl/dual_agu.sv
module dual_agu #(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          x_req,
  input  logic [1:0]    x_cmd,
  input  logic [AW-1:0] x_ptr,
  input  logic          x_circ_en,
  input  logic [AW-1:0] x_buf_start,
  input  logic [AW-1:0] x_buf_end,
  input  logic          x_brev_en,
  input  logic [AW-1:0] x_brev_mod,
  input  logic          y_req,
  input  logic [1:0]    y_cmd,
  input  logic [AW-1:0] y_ptr,
  input  logic          y_circ_en,
  input  logic [AW-1:0] y_buf_start,
  input  logic [AW-1:0] y_buf_end,
  output logic          x_valid,
  output logic [AW-1:0] x_ea,
  output logic [AW-1:0] x_next,
  output logic          y_valid,
  output logic [AW-1:0] y_ea,
  output logic [AW-1:0] y_next
);
  agu_port #(.AW(AW), .HAS_BREV(1'b1)) u_x (
    .clk       (clk),
    .rst       (rst),
    .req       (x_req),
    .cmd       (x_cmd),
    .ptr       (x_ptr),
    .circ_en   (x_circ_en),
    .buf_start (x_buf_start),
    .buf_end   (x_buf_end),
    .brev_en   (x_brev_en),
    .brev_mod  (x_brev_mod),
    .valid     (x_valid),
    .ea        (x_ea),
    .nxt       (x_next)
  );

  agu_port #(.AW(AW), .HAS_BREV(1'b0)) u_y (
    .clk       (clk),
    .rst       (rst),
    .req       (y_req),
    .cmd       (y_cmd),
    .ptr       (y_ptr),
    .circ_en   (y_circ_en),
    .buf_start (y_buf_start),
    .buf_end   (y_buf_end),
    .brev_en   (1'b0),
    .brev_mod  ('0),
    .valid     (y_valid),
    .ea        (y_ea),
    .nxt       (y_next)
  );
endmodule

// File: tb/dual_agu_tb_top.sv
module dual_agu_tb_top;
  typedef struct {
    logic [15:0] ea;
    logic [15:0] nxt;
    string       tag;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        x_req = 1'b0, y_req = 1'b0;
  logic [1:0]  x_cmd = '0, y_cmd = '0;
  logic [15:0] x_ptr = '0, y_ptr = '0;
  logic        x_circ_en = 1'b0, y_circ_en = 1'b0;
  logic [15:0] x_buf_start = '0, x_buf_end = '0, y_buf_start = '0, y_buf_end = '0;
  logic        x_brev_en = 1'b0;
  logic [15:0] x_brev_mod = '0;
  logic        x_valid, y_valid;
  logic [15:0] x_ea, x_next, y_ea, y_next;

  int   n_checks = 0;
  int   n_fail   = 0;
  bit   done     = 1'b0;
  exp_t xq[$];
  exp_t yq[$];

  always #4 clk = ~clk;

  dual_agu dut_i (
    .clk(clk), .rst(rst),
    .x_req(x_req), .x_cmd(x_cmd), .x_ptr(x_ptr), .x_circ_en(x_circ_en),
    .x_buf_start(x_buf_start), .x_buf_end(x_buf_end),
    .x_brev_en(x_brev_en), .x_brev_mod(x_brev_mod),
    .y_req(y_req), .y_cmd(y_cmd), .y_ptr(y_ptr), .y_circ_en(y_circ_en),
    .y_buf_start(y_buf_start), .y_buf_end(y_buf_end),
    .x_valid(x_valid), .x_ea(x_ea), .x_next(x_next),
    .y_valid(y_valid), .y_ea(y_ea), .y_next(y_next)
  );

  // Reference model written from the requirements.
  function automatic logic [15:0] model(input logic [15:0] p, input logic [1:0] c,
                                        input bit circ, input logic [15:0] s,
                                        input logic [15:0] e, input bit brev,
                                        input logic [15:0] m);
    logic [15:0] pa, sa, ea, r;
    logic        cy;
    pa = {p[15:1], 1'b0};
    sa = {s[15:1], 1'b0};
    ea = {e[15:1], 1'b0};
    if (c == 2'b01 && brev) begin
      r  = '0;
      cy = 1'b0;
      for (int i = 15; i >= 1; i--) begin
        r[i] = pa[i] ^ m[i] ^ cy;
        cy   = (pa[i] & m[i]) | (pa[i] & cy) | (m[i] & cy);
      end
      return r;
    end else if (c == 2'b01) begin
      return (circ && pa == ea) ? sa : pa + 16'd2;
    end else if (c == 2'b10) begin
      return (circ && pa == sa) ? ea : pa - 16'd2;
    end
    return pa;
  endfunction

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%04h expected 0x%04h", tag, act, exp);
    end
  endtask

  task automatic drive_x(input string tag, input logic [1:0] c, input logic [15:0] p,
                         input bit circ, input logic [15:0] s, input logic [15:0] e,
                         input bit brev, input logic [15:0] m);
    exp_t it;
    x_req = 1'b1; x_cmd = c; x_ptr = p; x_circ_en = circ;
    x_buf_start = s; x_buf_end = e; x_brev_en = brev; x_brev_mod = m;
    it.ea  = {p[15:1], 1'b0};
    it.nxt = model(p, c, circ, s, e, brev, m);
    it.tag = tag;
    xq.push_back(it);
  endtask

  task automatic drive_y(input string tag, input logic [1:0] c, input logic [15:0] p,
                         input bit circ, input logic [15:0] s, input logic [15:0] e);
    exp_t it;
    y_req = 1'b1; y_cmd = c; y_ptr = p; y_circ_en = circ;
    y_buf_start = s; y_buf_end = e;
    it.ea  = {p[15:1], 1'b0};
    it.nxt = model(p, c, circ, s, e, 1'b0, 16'h0);
    it.tag = tag;
    yq.push_back(it);
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    x_req = 1'b0;
    y_req = 1'b0;
  endtask

  // Monitor: scoreboard pops on each valid result.
  always begin : mon
    exp_t it;
    @(posedge clk);
    #2;
    if (!rst) begin
      if (x_valid) begin
        if (xq.size() == 0) begin
          n_checks++; n_fail++;
          $display("FAIL R2: unexpected x_valid, actual 1 expected 0");
        end else begin
          it = xq.pop_front();
          check({it.tag, " x_ea"}, x_ea, it.ea);
          check({it.tag, " x_next"}, x_next, it.nxt);
        end
      end
      if (y_valid) begin
        if (yq.size() == 0) begin
          n_checks++; n_fail++;
          $display("FAIL R2: unexpected y_valid, actual 1 expected 0");
        end else begin
          it = yq.pop_front();
          check({it.tag, " y_ea"}, y_ea, it.ea);
          check({it.tag, " y_next"}, y_next, it.nxt);
        end
      end
    end
  end

  initial begin : watchdog
    #(8 * 200000);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end

  initial begin : main
    logic [15:0] p;
    logic [15:0] last_ea;
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 x_valid", {15'd0, x_valid}, 16'd0);
    check("R1 x_ea", x_ea, 16'h0);
    check("R1 x_next", x_next, 16'h0);
    check("R1 y_valid", {15'd0, y_valid}, 16'd0);
    check("R1 y_next", y_next, 16'h0);
    rst = 1'b0;
    @(negedge clk);
    check("R1 post-reset y_ea", y_ea, 16'h0);

    // R3 linear increment, incl. wrap at top of space
    drive_x("R3 inc", 2'b01, 16'h1000, 0, 0, 0, 0, 0);
    drive_y("R3 inc y", 2'b01, 16'hFFFE, 0, 0, 0);
    tick();
    // R4 linear decrement, incl. wrap at bottom
    drive_x("R4 dec", 2'b10, 16'h0000, 0, 0, 0, 0, 0);
    drive_y("R4 dec y", 2'b10, 16'h3456, 0, 0, 0);
    tick();
    // R5 hold commands
    drive_x("R5 hold00", 2'b00, 16'h2222, 0, 0, 0, 0, 0);
    drive_y("R5 hold11", 2'b11, 16'h7778, 0, 0, 0);
    tick();
    // R12 odd pointer, odd bounds, odd modifier
    drive_x("R12 odd ptr", 2'b01, 16'h1235, 0, 0, 0, 0, 0);
    drive_y("R12 odd bounds", 2'b01, 16'h501F, 1, 16'h5001, 16'h501F);
    tick();
    last_ea = 16'h1234;
    // R2: idle cycle keeps outputs, valid low
    tick();
    check("R2 idle x_valid", {15'd0, x_valid}, 16'd0);
    check("R2 idle x_ea held", x_ea, last_ea);
    check("R2 idle x_next held", x_next, 16'h1236);

    // R6 circular increment: at end wraps, inside steps
    drive_x("R6 wrap", 2'b01, 16'h201E, 1, 16'h2000, 16'h201E, 0, 0);
    drive_y("R6 inside", 2'b01, 16'h2010, 1, 16'h2000, 16'h201E);
    tick();
    // R7 circular decrement
    drive_x("R7 inside", 2'b10, 16'h2010, 1, 16'h2000, 16'h201E, 0, 0);
    drive_y("R7 wrap", 2'b10, 16'h2000, 1, 16'h2000, 16'h201E);
    tick();

    // R8 bit-reversed sequence, fed back through own model
    p = 16'h4000;
    for (int k = 0; k < 10; k++) begin
      drive_x("R8 brev", 2'b01, p, 0, 0, 0, 1, 16'h0010);
      p = model(p, 2'b01, 0, 0, 0, 1, 16'h0010);
      tick();
    end
    drive_x("R8 carry drop", 2'b01, 16'h401E, 0, 0, 0, 1, 16'h0010);
    tick();
    drive_x("R8 wide mod", 2'b01, 16'h8AAA, 0, 0, 0, 1, 16'h0101);
    tick();

    // R9 + R11: X priority case and Y wrap in the same cycle
    drive_x("R9 brev over circ", 2'b01, 16'h4010, 1, 16'h4000, 16'h4010, 1, 16'h0010);
    drive_y("R11 y wrap alongside", 2'b01, 16'h6006, 1, 16'h6000, 16'h6006);
    tick();

    // R10 bit-reverse ignored on decrement and hold
    drive_x("R10 dec circ", 2'b10, 16'h4000, 1, 16'h4000, 16'h4010, 1, 16'h0010);
    tick();
    drive_x("R10 dec lin", 2'b10, 16'h4008, 0, 0, 0, 1, 16'h0010);
    tick();
    drive_x("R10 hold", 2'b11, 16'h4008, 0, 0, 0, 1, 16'h0010);
    tick();

    // R11 back-to-back independent requests
    for (int k = 0; k < 8; k++) begin
      drive_x("R11 x stream", 2'b01, 16'h0100 + 16'(k * 6), 0, 0, 0, 0, 0);
      drive_y("R11 y stream", 2'b10, 16'h0900 - 16'(k * 4), 1, 16'h08F8, 16'h0900);
      @(posedge clk);
      @(negedge clk);
    end
    x_req = 1'b0;
    y_req = 1'b0;
    repeat (3) @(negedge clk);

    n_checks++;
    if (xq.size() != 0 || yq.size() != 0) begin
      n_fail++;
      $display("FAIL R2: missing results, actual %0d pending expected 0", xq.size() + yq.size());
    end
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule